// File: doc/BRIEF.md
# Debug Break Condition Channel

This block is one hardware breakpoint channel for a processor core. It observes every bus cycle together with the in-order stream of instruction issues. When a programmed condition is met, it raises a user-break request toward the core. A condition is either a data access or an instruction fetch. A data access is qualified by the requesting master, the direction, the access size, the address and, optionally, the data value. An instruction fetch is made by the CPU, is a read, and is qualified by size and address. For fetch conditions, each fetched word carries a match tag through a short queue until the instruction issues. A fetch that a branch or interrupt redirect discards therefore never produces a break.

A fetch break is either taken before the matching instruction runs or after it completes. In both cases the request waits for an instruction boundary at which interrupts are accepted. An optional execution count delays the break until the Nth qualifying match. Two sticky flags, one for CPU-side conditions and one for other-master conditions, record matches until software clears them. A break is held in a pending bit. It is accepted once the core's 4-bit mask level drops below 15, the fixed level of this request.

Top module: `brk_channel`

## Requirements
- R1: A data condition (`cfg_data_cyc`=1) matches a bus cycle with `bus_valid`=1 and `bus_fetch`=0 only when master select, write bit, 2-bit size code and every address bit all equal the configured values. Any single difference gives no match.
- R2: With `cfg_data_cmp`=1, a data condition also requires `bus_data` to equal `cfg_data`. With `cfg_data_cmp`=0, the data value has no effect.
- R3: A fetch condition (`cfg_data_cyc`=0, master 0, write 0) tags a CPU fetch cycle whose size and address match, and `cfg_data`/`cfg_data_cmp` have no effect. A data cycle or a fetch of another size never matches it.
- R4: A tagged fetch produces a break only when it issues, in fetch order. A fetch alone raises nothing, and a fetch discarded by `pipe_flush` before issuing never breaks.
- R5: Pre-execution (`cfg_post`=0): when the tagged instruction issues with `ex_int_ok`=1, `brk_pending` is 1 right after that clock edge.
- R6: Post-execution (`cfg_post`=1): nothing is raised at the matching issue. The request is raised at the next later issue with `ex_int_ok`=1.
- R7: A break whose boundary has `ex_int_ok`=0 is deferred to the first later issue with `ex_int_ok`=1.
- R8: With `cfg_cnt_mode`=1, each qualifying match decrements `cnt_value`, which stops at 0. The flag and request occur only on the match that takes it from 1 to 0.
- R9: `cnt_load` writes `cnt_load_val` into `cnt_value` and takes priority over a match in the same cycle; that match is neither counted nor reported.
- R10: `flag_cpu` (condition on master 0) and `flag_bus` (master 1) are set one edge after a reported match. They stay set until the matching clear strobe, and a set in the same cycle as a clear wins.
- R11: `brk_accept` is 1 exactly while `brk_pending`=1 and `int_mask` is 14 or lower. After an accept with no new break, `brk_pending` is 0 at the next edge.
- R12: While `int_mask`=15, a pending break stays pending indefinitely.
- R13: After reset, the flags, `brk_pending`, `brk_accept` and `cnt_value` are 0 and the fetch queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_data_cyc | input | 1 | Condition kind: 1 data access, 0 instruction fetch |
| cfg_master_oth | input | 1 | Condition master: 0 CPU, 1 other bus master |
| cfg_write | input | 1 | Condition direction: 1 write, 0 read |
| cfg_size | input | 2 | Condition size code: 0 byte, 1 word, 2 long |
| cfg_addr | input | AW | Address compare value |
| cfg_data | input | DW | Data compare value |
| cfg_data_cmp | input | 1 | Enable data compare for data conditions |
| cfg_post | input | 1 | Fetch break timing: 0 before, 1 after execution |
| cfg_cnt_mode | input | 1 | Enable execution-count mode |
| cnt_load | input | 1 | Load strobe for the execution counter |
| cnt_load_val | input | CW | Counter load value |
| bus_valid | input | 1 | A bus cycle is present |
| bus_master_oth | input | 1 | Cycle master: 0 CPU, 1 other |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_write | input | 1 | Cycle is a write |
| bus_size | input | 2 | Cycle size code |
| bus_addr | input | AW | Cycle address |
| bus_data | input | DW | Cycle data |
| ex_issue | input | 1 | The oldest fetched instruction issues for execution |
| ex_int_ok | input | 1 | The boundary before the issuing instruction accepts interrupts |
| pipe_flush | input | 1 | Discard all fetched, not yet issued instructions |
| clr_cpu_flag | input | 1 | Software clear of the CPU-side flag |
| clr_bus_flag | input | 1 | Software clear of the other-master flag |
| int_mask | input | 4 | Core interrupt mask level |
| flag_cpu | output | 1 | Sticky CPU-side match flag |
| flag_bus | output | 1 | Sticky other-master match flag |
| brk_pending | output | 1 | Break request pending |
| brk_accept | output | 1 | Pending request accepted by the mask this cycle |
| cnt_value | output | CW | Current execution counter |

## Verification
The bench builds the channel with a 4-bit address, a 4-bit data word, a 3-bit counter and a 4-entry fetch queue. At those widths, every attribute combination can be crossed against every single-bit address miss, and every data value can be tried with the data compare on and off. All sixteen mask levels are covered, as is every count from 1 to 7. With the four-entry queue, every ok/not-ok pattern over three consecutive issue boundaries can be driven for both break timings.

// File: rtl/brk_pkg.sv
package brk_pkg;

    // Fixed priority level of the user-break request.
    localparam logic [3:0] BRK_LEVEL = 4'd15;

    // Attributes of a bus cycle that a condition compares.
    typedef struct packed {
        logic       master_oth;
        logic       write;
        logic [1:0] size;
    } cyc_attr_t;

    function automatic logic mask_admits(input logic [3:0] mask);
        return mask < BRK_LEVEL;
    endfunction

endpackage

// File: rtl/brk_attr_cmp.sv
module brk_attr_cmp
    import brk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          cfg_data_cyc,
    input  cyc_attr_t     cfg_attr,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_data,
    input  logic          cfg_data_cmp,
    input  logic          bus_valid,
    input  logic          bus_fetch,
    input  cyc_attr_t     bus_attr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          fetch_match,
    output logic          data_match
);

    logic attr_eq;
    logic addr_eq;
    logic data_ok;

    always_comb begin
        attr_eq = (cfg_attr == bus_attr);
        addr_eq = (cfg_addr == bus_addr);
        // Data value takes part only for data conditions with compare enabled.
        data_ok = !cfg_data_cmp || (cfg_data == bus_data);
        fetch_match = bus_valid && bus_fetch && !cfg_data_cyc && attr_eq && addr_eq
                      && !bus_attr.master_oth && !bus_attr.write;
        data_match  = bus_valid && !bus_fetch && cfg_data_cyc && attr_eq && addr_eq
                      && data_ok;
    end

endmodule

// File: rtl/brk_tag_queue.sv
module brk_tag_queue #(
    parameter int QD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_tag,
    input  logic pop,
    input  logic flush,
    output logic head_tag,
    output logic full
);

    localparam int CNTW = $clog2(QD + 1);
    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(QD);

    typedef struct packed {
        logic [QD-1:0]   tags;
        logic [CNTW-1:0] cnt;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        // Oldest entry leaves first when it issues.
        if (pop && q_q.cnt != '0) begin
            q_d.tags = q_q.tags >> 1;
            q_d.cnt  = q_q.cnt - 1'b1;
        end
        // Redirect discards everything still waiting.
        if (flush) begin
            q_d.cnt = '0;
        end
        // A fetch in the redirect cycle belongs to the new path and is kept.
        if (push && q_d.cnt != DEPTH_C) begin
            for (int i = 0; i < QD; i++) begin
                if (i == int'(q_d.cnt)) begin
                    q_d.tags[i] = push_tag;
                end
            end
            q_d.cnt = q_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head_tag = q_q.tags[0] && (q_q.cnt != '0);
    assign full     = (q_q.cnt == DEPTH_C);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop && !flush));

    p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !push) |=> (q_q.cnt == '0));

endmodule

// File: rtl/brk_exec_count.sv
module brk_exec_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          qual,
    output logic          hit,
    output logic [CW-1:0] value
);

    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic [CW-1:0] count;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        hit = 1'b0;
        if (load) begin
            c_d.count = load_val;
        end else if (mode && qual && c_q.count != '0) begin
            c_d.count = c_q.count - 1'b1;
        end
        if (!mode) begin
            hit = qual;
        end else begin
            hit = qual && !load && (c_q.count == ONE_C);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign value = c_q.count;

    p_stop_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.count == '0 && !load) |=> (c_q.count == '0));

    p_hit_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode) |=> (c_q.count == '0));

endmodule

// File: rtl/brk_req_gate.sv
module brk_req_gate
    import brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_hit,
    input  logic       data_hit,
    input  logic       hit_bus_side,
    input  logic       post,
    input  logic       ex_issue,
    input  logic       ex_int_ok,
    input  logic       clr_cpu,
    input  logic       clr_bus,
    input  logic [3:0] int_mask,
    output logic       flag_cpu,
    output logic       flag_bus,
    output logic       pending,
    output logic       accept
);

    typedef struct packed {
        logic armed;
        logic pending;
        logic flag_cpu;
        logic flag_bus;
    } gate_t;

    gate_t s_d, s_q;
    logic  hit;
    logic  fire_now;
    logic  arm_set;
    logic  armed_fire;
    logic  fire;

    always_comb begin
        hit        = fetch_hit || data_hit;
        // Pre-execution break at an accepting boundary goes out at once.
        fire_now   = fetch_hit && !post && ex_int_ok;
        // Post-execution, or a boundary that refuses interrupts: wait.
        arm_set    = fetch_hit && (post || !ex_int_ok);
        armed_fire = s_q.armed && ex_issue && ex_int_ok;
        fire       = fire_now || armed_fire || data_hit;
        accept     = s_q.pending && mask_admits(int_mask);

        s_d          = s_q;
        s_d.armed    = (s_q.armed && !armed_fire) || arm_set;
        s_d.pending  = fire || (s_q.pending && !accept);
        s_d.flag_cpu = (s_q.flag_cpu && !clr_cpu) || (hit && !hit_bus_side);
        s_d.flag_bus = (s_q.flag_bus && !clr_bus) || (hit && hit_bus_side);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_cpu = s_q.flag_cpu;
    assign flag_bus = s_q.flag_bus;
    assign pending  = s_q.pending;

    p_sticky_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag_cpu && !clr_cpu) |=> s_q.flag_cpu);

    p_sticky_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag_bus && !clr_bus) |=> s_q.flag_bus);

    p_hold_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pending && int_mask == BRK_LEVEL) |=> s_q.pending);

    p_accept_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !fire) |=> !s_q.pending);

    p_post_defers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hit && post) |=> s_q.armed);

endmodule

// File: rtl/brk_channel.sv
module brk_channel
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 12,
    parameter int QD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_data_cyc,
    input  logic          cfg_master_oth,
    input  logic          cfg_write,
    input  logic [1:0]    cfg_size,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_data,
    input  logic          cfg_data_cmp,
    input  logic          cfg_post,
    input  logic          cfg_cnt_mode,
    input  logic          cnt_load,
    input  logic [CW-1:0] cnt_load_val,
    input  logic          bus_valid,
    input  logic          bus_master_oth,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          ex_issue,
    input  logic          ex_int_ok,
    input  logic          pipe_flush,
    input  logic          clr_cpu_flag,
    input  logic          clr_bus_flag,
    input  logic [3:0]    int_mask,
    output logic          flag_cpu,
    output logic          flag_bus,
    output logic          brk_pending,
    output logic          brk_accept,
    output logic [CW-1:0] cnt_value
);

    cyc_attr_t cfg_attr;
    cyc_attr_t bus_attr;
    logic      fetch_match;
    logic      data_match;
    logic      q_push;
    logic      q_head;
    logic      q_full;
    logic      fetch_qual;
    logic      qual;
    logic      hit;

    always_comb begin
        cfg_attr.master_oth = cfg_master_oth;
        cfg_attr.write      = cfg_write;
        cfg_attr.size       = cfg_size;
        bus_attr.master_oth = bus_master_oth;
        bus_attr.write      = bus_write;
        bus_attr.size       = bus_size;
    end

    brk_attr_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .cfg_data_cyc (cfg_data_cyc),
        .cfg_attr     (cfg_attr),
        .cfg_addr     (cfg_addr),
        .cfg_data     (cfg_data),
        .cfg_data_cmp (cfg_data_cmp),
        .bus_valid    (bus_valid),
        .bus_fetch    (bus_fetch),
        .bus_attr     (bus_attr),
        .bus_addr     (bus_addr),
        .bus_data     (bus_data),
        .fetch_match  (fetch_match),
        .data_match   (data_match)
    );

    assign q_push = bus_valid && bus_fetch && !bus_master_oth;

    brk_tag_queue #(.QD(QD)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_tag (fetch_match),
        .pop      (ex_issue),
        .flush    (pipe_flush),
        .head_tag (q_head),
        .full     (q_full)
    );

    // A fetch condition qualifies only when its tagged instruction issues.
    assign fetch_qual = ex_issue && q_head && !cfg_data_cyc;
    assign qual       = fetch_qual || data_match;

    brk_exec_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_cnt_mode),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .qual     (qual),
        .hit      (hit),
        .value    (cnt_value)
    );

    brk_req_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_hit    (hit && !cfg_data_cyc),
        .data_hit     (hit && cfg_data_cyc),
        .hit_bus_side (cfg_master_oth),
        .post         (cfg_post),
        .ex_issue     (ex_issue),
        .ex_int_ok    (ex_int_ok),
        .clr_cpu      (clr_cpu_flag),
        .clr_bus      (clr_bus_flag),
        .int_mask     (int_mask),
        .flag_cpu     (flag_cpu),
        .flag_bus     (flag_bus),
        .pending      (brk_pending),
        .accept       (brk_accept)
    );

    p_queue_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_push && q_full && !ex_issue && !pipe_flush));

endmodule

// File: tb/sim_brk_channel.sv
module sim_brk_channel;

    localparam int AW = 4;
    localparam int DW = 4;
    localparam int CW = 3;
    localparam int QD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_data_cyc = 1'b1, cfg_master_oth = 1'b0, cfg_write = 1'b0;
    logic [1:0]    cfg_size = 2'd1;
    logic [AW-1:0] cfg_addr = 4'h9;
    logic [DW-1:0] cfg_data = 4'h5;
    logic          cfg_data_cmp = 1'b0, cfg_post = 1'b0, cfg_cnt_mode = 1'b0;
    logic          cnt_load = 1'b0;
    logic [CW-1:0] cnt_load_val = '0;
    logic          bus_valid = 1'b0, bus_master_oth = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [1:0]    bus_size = 2'd1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic          ex_issue = 1'b0, ex_int_ok = 1'b0, pipe_flush = 1'b0;
    logic          clr_cpu_flag = 1'b0, clr_bus_flag = 1'b0;
    logic [3:0]    int_mask = 4'hF;
    logic          flag_cpu, flag_bus, brk_pending, brk_accept;
    logic [CW-1:0] cnt_value;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    brk_channel #(.AW(AW), .DW(DW), .CW(CW), .QD(QD)) u0 (.*);

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle;
        bus_valid = 1'b0; ex_issue = 1'b0; pipe_flush = 1'b0;
        cnt_load = 1'b0; clr_cpu_flag = 1'b0; clr_bus_flag = 1'b0;
    endtask

    task automatic drain;
        idle;
        int_mask = 4'h0; clr_cpu_flag = 1'b1; clr_bus_flag = 1'b1;
        tick;
        clr_cpu_flag = 1'b0; clr_bus_flag = 1'b0;
    endtask

    task automatic data_cyc(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_valid = 1'b1; bus_fetch = 1'b0; bus_master_oth = 1'b0;
        bus_write = 1'b0; bus_size = 2'd1; bus_addr = a; bus_data = d;
    endtask

    task automatic fetch_cyc(input logic [AW-1:0] a, input logic [1:0] sz);
        bus_valid = 1'b1; bus_fetch = 1'b1; bus_master_oth = 1'b0;
        bus_write = 1'b0; bus_size = sz; bus_addr = a; bus_data = 4'h0;
    endtask

    task automatic data_cfg;
        cfg_data_cyc = 1'b1; cfg_master_oth = 1'b0; cfg_write = 1'b0;
        cfg_size = 2'd1; cfg_addr = 4'h9; cfg_data = 4'h5; cfg_data_cmp = 1'b0;
    endtask

    task automatic fetch_cfg(input logic post);
        cfg_data_cyc = 1'b0; cfg_master_oth = 1'b0; cfg_write = 1'b0;
        cfg_size = 2'd1; cfg_addr = 4'h9; cfg_data = 4'h5; cfg_data_cmp = 1'b1;
        cfg_post = post;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tick; tick;
        // R13: reset state
        chk("R13 flag_cpu", flag_cpu, 0);
        chk("R13 flag_bus", flag_bus, 0);
        chk("R13 pending", brk_pending, 0);
        chk("R13 accept", brk_accept, 0);
        chk("R13 cnt_value", cnt_value, 0);
        rst_n = 1'b1;
        tick;

        // R1: attribute cross with single-bit address misses
        data_cfg;
        for (int cm = 0; cm < 2; cm++)
        for (int cw = 0; cw < 2; cw++)
        for (int cs = 0; cs < 4; cs++)
        for (int bm = 0; bm < 2; bm++)
        for (int bw = 0; bw < 2; bw++)
        for (int bs = 0; bs < 4; bs++)
        for (int ai = 0; ai < 5; ai++) begin
            logic e;
            cfg_master_oth = cm[0]; cfg_write = cw[0]; cfg_size = 2'(cs);
            bus_valid = 1'b1; bus_fetch = 1'b0;
            bus_master_oth = bm[0]; bus_write = bw[0]; bus_size = 2'(bs);
            bus_addr = (ai == 0) ? 4'h9 : (4'h9 ^ 4'(1 << (ai - 1)));
            bus_data = 4'h0;
            int_mask = 4'hF;
            tick;
            e = (cm == bm) && (cw == bw) && (cs == bs) && (ai == 0);
            chk("R1 flag_cpu", flag_cpu, e && cm == 0);
            chk("R1 flag_bus", flag_bus, e && cm == 1);
            chk("R1 pending", brk_pending, e);
            drain;
        end

        // R2: optional data compare
        data_cfg;
        for (int de = 0; de < 2; de++)
        for (int bd = 0; bd < 16; bd++) begin
            cfg_data_cmp = de[0];
            data_cyc(4'h9, 4'(bd));
            int_mask = 4'hF;
            tick;
            chk("R2 flag_cpu", flag_cpu, (de == 0) || (bd == 5));
            chk("R2 pending", brk_pending, (de == 0) || (bd == 5));
            drain;
        end

        // R3/R4: fetch condition ignores data; fetch alone raises nothing
        fetch_cfg(1'b0);
        for (int bd = 0; bd < 16; bd++) begin
            fetch_cyc(4'h9, 2'd1);
            bus_data = 4'(bd);
            int_mask = 4'hF;
            tick;
            chk("R4 fetch only pending", brk_pending, 0);
            chk("R4 fetch only flag", flag_cpu, 0);
            bus_valid = 1'b0; ex_issue = 1'b1; ex_int_ok = 1'b1;
            tick;
            ex_issue = 1'b0;
            chk("R3 fetch flag", flag_cpu, 1);
            chk("R3 fetch pending", brk_pending, 1);
            drain;
        end
        // R3: data cycle at fetch address, and fetch of wrong size
        data_cyc(4'h9, 4'h5);
        tick;
        chk("R3 data cycle vs fetch cond", flag_cpu, 0);
        fetch_cyc(4'h9, 2'd0);
        tick;
        bus_valid = 1'b0; ex_issue = 1'b1; ex_int_ok = 1'b1;
        tick;
        ex_issue = 1'b0;
        chk("R3 wrong size pending", brk_pending, 0);
        chk("R3 wrong size flag", flag_cpu, 0);
        drain;

        // R4: flushed fetch never breaks
        fetch_cyc(4'h9, 2'd1);
        tick;
        bus_valid = 1'b0; pipe_flush = 1'b1;
        tick;
        pipe_flush = 1'b0;
        fetch_cyc(4'h8, 2'd1);
        tick;
        bus_valid = 1'b0; ex_issue = 1'b1; ex_int_ok = 1'b1;
        tick;
        ex_issue = 1'b0;
        chk("R4 flushed pending", brk_pending, 0);
        chk("R4 flushed flag", flag_cpu, 0);
        // R4: issue order follows fetch order
        int_mask = 4'hF;
        fetch_cyc(4'h8, 2'd1);
        tick;
        fetch_cyc(4'h9, 2'd1);
        tick;
        bus_valid = 1'b0; ex_issue = 1'b1; ex_int_ok = 1'b1;
        tick;
        chk("R4 first issue pending", brk_pending, 0);
        tick;
        ex_issue = 1'b0;
        chk("R4 second issue pending", brk_pending, 1);
        chk("R4 second issue flag", flag_cpu, 1);
        drain;

        // R5/R6/R7: break timing over every ok pattern
        for (int post = 0; post < 2; post++)
        for (int pat = 0; pat < 8; pat++) begin
            int fire;
            string tag;
            fetch_cfg(post[0]);
            int_mask = 4'h0;
            fetch_cyc(4'h9, 2'd1);
            tick;
            for (int k = 0; k < 3; k++) begin
                fetch_cyc(4'h8, 2'd1);
                tick;
            end
            bus_valid = 1'b0;
            fire = -1;
            for (int i = post; i < 3; i++) begin
                if (pat[i] && fire < 0) fire = i;
            end
            tag = (post == 1) ? "R6 post timing" : (pat[0] ? "R5 pre timing" : "R7 deferred");
            for (int i = 0; i < 3; i++) begin
                ex_issue = 1'b1; ex_int_ok = pat[i];
                tick;
                chk(tag, brk_pending, i == fire);
                if (i == 0) chk("R5 issue sets flag", flag_cpu, 1);
            end
            ex_issue = 1'b1; ex_int_ok = 1'b1;
            tick;
            chk("R7 final boundary", brk_pending, fire < 0);
            ex_issue = 1'b0;
            drain;
        end

        // R8/R9: execution count on data matches
        data_cfg;
        cfg_cnt_mode = 1'b1;
        for (int n = 1; n < 8; n++) begin
            cnt_load = 1'b1; cnt_load_val = 3'(n);
            tick;
            cnt_load = 1'b0;
            chk("R9 loaded", cnt_value, n);
            int_mask = 4'h0;
            for (int k = 1; k <= n + 2; k++) begin
                data_cyc(4'h9, 4'h0);
                tick;
                chk("R8 flag", flag_cpu, k >= n);
                chk("R8 pending", brk_pending, k == n);
                chk("R8 count", cnt_value, (k < n) ? (n - k) : 0);
            end
            drain;
        end
        // R9: load wins over a same-cycle match
        data_cyc(4'h9, 4'h0);
        cnt_load = 1'b1; cnt_load_val = 3'd3;
        tick;
        cnt_load = 1'b0;
        chk("R9 load wins count", cnt_value, 3);
        chk("R9 load wins flag", flag_cpu, 0);
        chk("R9 load wins pending", brk_pending, 0);
        // R8: stopped at zero, nothing reported
        bus_valid = 1'b0; cnt_load = 1'b1; cnt_load_val = 3'd0;
        tick;
        cnt_load = 1'b0;
        for (int k = 0; k < 2; k++) begin
            data_cyc(4'h9, 4'h0);
            tick;
            chk("R8 zero flag", flag_cpu, 0);
            chk("R8 zero pending", brk_pending, 0);
            chk("R8 zero count", cnt_value, 0);
        end
        cfg_cnt_mode = 1'b0;
        drain;

        // R10: set beats clear; sticky until cleared
        data_cyc(4'h9, 4'h0);
        clr_cpu_flag = 1'b1;
        tick;
        chk("R10 set wins", flag_cpu, 1);
        idle;
        repeat (3) tick;
        chk("R10 sticky", flag_cpu, 1);
        chk("R10 other flag", flag_bus, 0);
        clr_cpu_flag = 1'b1;
        tick;
        clr_cpu_flag = 1'b0;
        chk("R10 cleared", flag_cpu, 0);
        drain;

        // R11/R12: every mask level
        for (int m = 0; m < 16; m++) begin
            data_cyc(4'h9, 4'h0);
            int_mask = 4'(m);
            tick;
            bus_valid = 1'b0;
            chk("R11 pending", brk_pending, 1);
            chk("R11 accept", brk_accept, m < 15);
            for (int h = 0; h < 3; h++) begin
                tick;
                chk((m == 15) ? "R12 held" : "R11 cleared", brk_pending, m == 15);
            end
            drain;
            chk("R12 released", brk_pending, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule